// File: doc/BRIEF.md
# Lane Word Aligner with Polarity Correction

This block sits behind a 10-bit deserializer whose word boundary is arbitrary. Every clock it takes one raw word. Within each word, the bit that arrived first on the wire is the MSB. The block looks for the 8b/10b comma symbol at every possible bit offset, in a window made of the previous word and the current word. Once the comma recurs at one offset with the ordered-set spacing of 16 symbols, the block locks. From then on it emits symbols cut at that offset.

While locked, the block checks the payload of training sets to find out whether the differential pair is swapped. The comma looks the same in either polarity, so alignment never depends on the pair orientation. The payload does tell the two orientations apart. When enough training sets agree that the pair is swapped, the block inverts every later symbol. Downstream logic (8b/10b decoding, link training) receives the aligned symbols, a lock flag, a marker on each ordered-set start and a flag telling whether each symbol was inverted.

Top module: `wa_lane_align`

## Requirements
- R1: The comma is recognised at any of the 10 bit offsets, in either running-disparity form: 0011111010 or 1100000101, MSB first on the wire.
- R2: `lock_o` rises together with the output of the third comma found at one offset with a spacing of exactly 16 symbols. It stays low before that comma.
- R3: While locked, `sym_o` carries the received symbol cut at the locked offset, XOR-ed with the inversion. It appears at the clock edge that samples the raw word completing that symbol.
- R4: While locked, one to three consecutive expected ordered-set starts without a comma keep lock. A good start resets this miss count. The fourth consecutive miss drops `lock_o` on that same output slot.
- R5: After lock is lost, the search starts again and locks on the third comma of the new run.
- R6: `sos_o` is high on every 16th output slot, counted from the slot that gained lock, for as long as lock holds. It is low at all other times.
- R7: A training-set verdict is formed only for a set whose comma is seen while locked. All of its symbols 6 to 15 must equal 0101010101 (verdict: straight) or all must equal 1010101010 (verdict: swapped). Any other payload gives no verdict and does not break a pending agreement.
- R8: The inversion state takes a verdict only when two verdicts in a row agree. A set with no verdict does not count as a verdict. The new state applies from the output slot after the last payload symbol of the second set.
- R9: `inv_o` is high exactly on output slots whose symbol was inverted.
- R10: A synchronous reset clears lock, start marker, inversion and the output symbol.
- R11: A fully inverted line stream locks on the same slot as a straight one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one raw word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 10 | Raw deserializer word, first bit on the wire in the MSB |
| sym_o | output | 10 | Aligned symbol, inverted when inv_o is high |
| lock_o | output | 1 | Boundary lock held |
| sos_o | output | 1 | Slot is an ordered-set start while locked |
| inv_o | output | 1 | This slot's symbol was inverted |

## Verification
The polarity commit and the ordered-set boundary fall on the same output slot. The swapped verdict is taken on the last payload symbol of a set, so the first inverted symbol is always the next comma slot, which also carries `sos_o`. A swapped stream provokes this, and the scoreboard expects `sym_o` in straight form together with `inv_o` and `sos_o` on exactly that slot, with the slot before it still raw. A second coincidence is checked the same way: the fourth missing comma must clear `lock_o` and suppress `sos_o` on the same slot.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int SYM_W = 10;
    localparam int OFF_W = $clog2(SYM_W);

    typedef logic [SYM_W-1:0] sym_t;

    // comma in both running-disparity forms, MSB first on the wire
    localparam sym_t COMMA_RDN  = 10'b0011111010;
    localparam sym_t COMMA_RDP  = 10'b1100000101;
    // training payload as seen on a straight pair and on a swapped pair
    localparam sym_t TRAIN_NORM = 10'b0101010101;
    localparam sym_t TRAIN_FLIP = 10'b1010101010;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } align_st_e;

    typedef struct packed {
        sym_t sym;
        logic lock;
        logic sos;
        logic inv;
    } lane_out_t;

    function automatic logic is_comma(sym_t s);
        return (s == COMMA_RDN) || (s == COMMA_RDP);
    endfunction

    function automatic sym_t flip(sym_t s, logic en);
        return en ? ~s : s;
    endfunction

endpackage

// File: rtl/wa_comma_scan.sv
module wa_comma_scan
    import wa_pkg::*;
(
    input  sym_t               prev_w,
    input  logic [SYM_W-2:0]   cur_head,
    output logic [SYM_W-1:0]   hit,
    output sym_t               cand [SYM_W]
);

    // previous word followed by the first nine bits of the current word
    logic [2*SYM_W-2:0] window;
    assign window = {prev_w, cur_head};

    for (genvar k = 0; k < SYM_W; k++) begin : g_off
        assign cand[k] = window[2*SYM_W-2-k -: SYM_W];
        assign hit[k]  = is_comma(cand[k]);
    end

endmodule

// File: rtl/wa_lock_fsm.sv
module wa_lock_fsm
    import wa_pkg::*;
#(
    parameter  int OS_LEN     = 16,
    parameter  int LOCK_HITS  = 3,
    parameter  int MISS_LIMIT = 4,
    localparam int POS_W      = $clog2(OS_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] hit,
    output logic [OFF_W-1:0] off,
    output logic [POS_W-1:0] pos,
    output logic             locked,
    output logic             lock_nxt,
    output logic             at_start,
    output logic             start_hit
);

    localparam int GOOD_W = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_HITS);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT);
    localparam logic [POS_W-1:0]  POS_LAST = POS_W'(OS_LEN - 1);

    align_st_e         st_q, st_d;
    logic [OFF_W-1:0]  off_q, off_d, first_off;
    logic [POS_W-1:0]  pos_q, pos_d, pos_step;
    logic [GOOD_W-1:0] good_q, good_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              any_hit;

    always_comb begin
        any_hit   = |hit;
        first_off = '0;
        for (int k = SYM_W - 1; k >= 0; k--) begin
            if (hit[k]) first_off = OFF_W'(k);
        end
        at_start  = (st_q != ST_HUNT) && (pos_q == '0);
        start_hit = hit[off_q];
        pos_step  = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

        st_d   = st_q;
        off_d  = off_q;
        pos_d  = pos_step;
        good_d = good_q;
        miss_d = miss_q;

        unique case (st_q)
            ST_HUNT: begin
                pos_d = '0;
                if (any_hit) begin
                    off_d  = first_off;
                    pos_d  = POS_W'(1);
                    good_d = GOOD_W'(1);
                    miss_d = '0;
                    st_d   = (GOOD_TOP == GOOD_W'(1)) ? ST_LOCKED : ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (at_start) begin
                    if (start_hit) begin
                        good_d = good_q + 1'b1;
                        if (good_q + 1'b1 == GOOD_TOP) st_d = ST_LOCKED;
                    end else begin
                        st_d = ST_HUNT;
                    end
                end
            end
            ST_LOCKED: begin
                if (at_start) begin
                    if (start_hit) begin
                        miss_d = '0;
                    end else begin
                        miss_d = miss_q + 1'b1;
                        if (miss_q + 1'b1 == MISS_TOP) st_d = ST_HUNT;
                    end
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            off_q  <= '0;
            pos_q  <= '0;
            good_q <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            off_q  <= off_d;
            pos_q  <= pos_d;
            good_q <= good_d;
            miss_q <= miss_d;
        end
    end

    assign off      = off_q;
    assign pos      = pos_q;
    assign locked   = (st_q == ST_LOCKED);
    assign lock_nxt = (st_d == ST_LOCKED);

    AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCKED) |=> $stable(off_q)); // R3

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCKED) |-> (miss_q < MISS_TOP)); // R4

    AST_LOCK_VIA_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_LOCKED) && !$past(st_q == ST_LOCKED)) |-> $past(st_q == ST_CONFIRM)); // R2

endmodule

// File: rtl/wa_polarity.sv
module wa_polarity
    import wa_pkg::*;
#(
    parameter  int OS_LEN        = 16,
    parameter  int PAYLOAD_FIRST = 6,
    parameter  int AGREE_N       = 2,
    localparam int POS_W         = $clog2(OS_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic             at_start,
    input  logic             start_hit,
    input  logic [POS_W-1:0] pos,
    input  sym_t             sym,
    output logic             inv
);

    localparam int CNT_W = $clog2(AGREE_N + 1);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(AGREE_N);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(PAYLOAD_FIRST);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(OS_LEN - 1);

    logic             track_q, track_d;
    logic             norm_q, norm_d, flip_q, flip_d;
    logic             pend_v_q, pend_v_d, pend_q, pend_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             inv_q, inv_d;
    logic             norm_all, flip_all, in_payload;
    logic             verdict_v, verdict;

    always_comb begin
        in_payload = (pos >= POS_FIRST);
        norm_all   = norm_q && (!in_payload || (sym == TRAIN_NORM));
        flip_all   = flip_q && (!in_payload || (sym == TRAIN_FLIP));

        track_d   = track_q;
        norm_d    = norm_q;
        flip_d    = flip_q;
        pend_v_d  = pend_v_q;
        pend_d    = pend_q;
        cnt_d     = cnt_q;
        inv_d     = inv_q;
        verdict_v = 1'b0;
        verdict   = 1'b0;

        if (!locked) begin
            track_d  = 1'b0;
            pend_v_d = 1'b0;
            cnt_d    = '0;
        end else if (at_start) begin
            track_d = start_hit;
            norm_d  = 1'b1;
            flip_d  = 1'b1;
        end else if (track_q) begin
            norm_d = norm_all;
            flip_d = flip_all;
            if (pos == POS_LAST) begin
                track_d   = 1'b0;
                verdict_v = norm_all || flip_all;
                verdict   = flip_all;
            end
        end

        if (verdict_v) begin
            if (pend_v_q && (verdict == pend_q))
                cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
            else
                cnt_d = CNT_W'(1);
            pend_d   = verdict;
            pend_v_d = 1'b1;
            if (cnt_d == CNT_TOP) inv_d = verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            track_q  <= 1'b0;
            norm_q   <= 1'b0;
            flip_q   <= 1'b0;
            pend_v_q <= 1'b0;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            inv_q    <= 1'b0;
        end else begin
            track_q  <= track_d;
            norm_q   <= norm_d;
            flip_q   <= flip_d;
            pend_v_q <= pend_v_d;
            pend_q   <= pend_d;
            cnt_q    <= cnt_d;
            inv_q    <= inv_d;
        end
    end

    assign inv = inv_q;

    AST_INV_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        !$stable(inv_q) |-> $past(locked)); // R8

    AST_TRACK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        track_q |-> $past(locked)); // R7

endmodule

// File: rtl/wa_lane_align.sv
module wa_lane_align
    import wa_pkg::*;
#(
    parameter int OS_LEN        = 16,
    parameter int LOCK_HITS     = 3,
    parameter int MISS_LIMIT    = 4,
    parameter int PAYLOAD_FIRST = 6,
    parameter int AGREE_N       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] rx_word,
    output logic [SYM_W-1:0] sym_o,
    output logic             lock_o,
    output logic             sos_o,
    output logic             inv_o
);

    localparam int POS_W = $clog2(OS_LEN);

    sym_t             prev_q;
    sym_t             cand [SYM_W];
    logic [SYM_W-1:0] hit;
    logic [OFF_W-1:0] off;
    logic [POS_W-1:0] pos;
    logic             locked, lock_nxt, at_start, start_hit, inv;
    sym_t             aligned;
    lane_out_t        out_q, out_d;

    wa_comma_scan u_scan (
        .prev_w   (prev_q),
        .cur_head (rx_word[SYM_W-1:1]),
        .hit      (hit),
        .cand     (cand)
    );

    wa_lock_fsm #(
        .OS_LEN     (OS_LEN),
        .LOCK_HITS  (LOCK_HITS),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .off       (off),
        .pos       (pos),
        .locked    (locked),
        .lock_nxt  (lock_nxt),
        .at_start  (at_start),
        .start_hit (start_hit)
    );

    assign aligned = cand[off];

    wa_polarity #(
        .OS_LEN        (OS_LEN),
        .PAYLOAD_FIRST (PAYLOAD_FIRST),
        .AGREE_N       (AGREE_N)
    ) u_pol (
        .clk       (clk),
        .rst       (rst),
        .locked    (locked),
        .at_start  (at_start),
        .start_hit (start_hit),
        .pos       (pos),
        .sym       (aligned),
        .inv       (inv)
    );

    always_comb begin
        out_d.sym  = flip(aligned, inv);
        out_d.lock = lock_nxt;
        out_d.sos  = lock_nxt && at_start;
        out_d.inv  = inv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            out_q  <= '0;
        end else begin
            prev_q <= rx_word;
            out_q  <= out_d;
        end
    end

    assign sym_o  = out_q.sym;
    assign lock_o = out_q.lock;
    assign sos_o  = out_q.sos;
    assign inv_o  = out_q.inv;

    AST_LOCK_RISE_AT_SOS: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> sos_o); // R2

    AST_SOS_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        sos_o |-> lock_o); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lock_o && !inv_o && !sos_o)); // R10

endmodule

// File: tb/wa_lane_align_tb.sv
module wa_lane_align_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXSYM     = 400;
    localparam logic [9:0] K_COMMA = 10'b0011111010;
    localparam logic [9:0] D_NORM  = 10'b0101010101;
    localparam logic [9:0] D_FLIP  = 10'b1010101010;
    localparam logic [9:0] D_OTHER = 10'b1010010101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] rx_word = '0;
    logic [9:0] sym_o;
    logic       lock_o, sos_o, inv_o;

    typedef struct {
        logic [9:0] sym;
        logic       lock;
        logic       sos;
        logic       inv;
    } exp_t;

    exp_t       exp_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [9:0] tx [MAXSYM];
    logic       e_lock [MAXSYM];
    logic       e_sos  [MAXSYM];
    logic       e_inv  [MAXSYM];
    int         nsym = 0;
    int         g_shift = 0;
    logic       g_swap = 1'b0;

    wa_lane_align u_dut (
        .clk     (clk),
        .rst     (rst),
        .rx_word (rx_word),
        .sym_o   (sym_o),
        .lock_o  (lock_o),
        .sos_o   (sos_o),
        .inv_o   (inv_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [9:0] act, logic [9:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: pops one expected slot per output edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check("R2/R4/R5 lock_o", {9'd0, lock_o}, {9'd0, e.lock});
                check("R6 sos_o", {9'd0, sos_o}, {9'd0, e.sos});
                check("R9 inv_o", {9'd0, inv_o}, {9'd0, e.inv});
                if (e.lock) check("R3 sym_o", sym_o, e.sym);
            end
        end
    end

    // kind: 0 straight training, 1 swapped-looking payload, 2 other payload, 3 no comma
    task automatic put_set(int k, int kind);
        for (int p = 0; p < 16; p++) begin
            if (p == 0)      tx[16*k+p] = (kind == 3) ? D_NORM : K_COMMA;
            else if (p < 6)  tx[16*k+p] = D_NORM;
            else if (kind == 1) tx[16*k+p] = D_FLIP;
            else if (kind == 2) tx[16*k+p] = D_OTHER;
            else             tx[16*k+p] = D_NORM;
        end
    endtask

    task automatic fill_exp(int lock_from, int inv_from);
        for (int j = 0; j < nsym; j++) begin
            e_lock[j] = (j >= lock_from);
            e_sos[j]  = e_lock[j] && (j % 16 == 0);
            e_inv[j]  = (j >= inv_from);
        end
    endtask

    function automatic logic [9:0] word_at(int n);
        logic [9:0] w;
        int b, s, p;
        logic bv;
        for (int i = 0; i < 10; i++) begin
            b = 10*n + i;
            if (b < g_shift) bv = 1'b0;
            else begin
                s  = (b - g_shift) / 10;
                p  = (b - g_shift) % 10;
                bv = (s < nsym) ? tx[s][9-p] : 1'b0;
            end
            w[9-i] = bv ^ g_swap;
        end
        return w;
    endfunction

    task automatic run_stream(int shift, logic swap);
        exp_t e;
        logic [9:0] rx;
        g_shift = shift;
        g_swap  = swap;
        for (int n = 0; n <= nsym; n++) begin
            @(negedge clk);
            rx_word = word_at(n);
            if (n >= 1) begin
                rx     = tx[n-1] ^ {10{swap}};
                e.sym  = rx ^ {10{e_inv[n-1]}};
                e.lock = e_lock[n-1];
                e.sos  = e_sos[n-1];
                e.inv  = e_inv[n-1];
                exp_q.push_back(e);
            end
        end
        @(posedge clk);
        #(CLK_PERIOD/4 + 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_word = '0;
        exp_q.delete();
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R10 lock_o after reset", {9'd0, lock_o}, 10'd0);
        check("R10 sos_o after reset", {9'd0, sos_o}, 10'd0);
        check("R10 inv_o after reset", {9'd0, inv_o}, 10'd0);
        check("R10 sym_o after reset", sym_o, 10'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // A: straight pair, offset 3; R1 comma found off-boundary, R7 straight verdicts keep inversion clear
        nsym = 96;
        for (int k = 0; k < 6; k++) put_set(k, 0);
        fill_exp(32, 100000);
        run_stream(3, 1'b0);
        check("R1 locked at offset 3", {9'd0, lock_o}, 10'd1);
        check("R7 straight payload leaves inversion clear", {9'd0, inv_o}, 10'd0);

        // B: swapped pair, offset 7; R11 lock on inverted commas, R8 commit after two sets
        do_reset();
        nsym = 96;
        for (int k = 0; k < 6; k++) put_set(k, 0);
        fill_exp(32, 80);
        run_stream(7, 1'b1);
        check("R11 swapped stream locked", {9'd0, lock_o}, 10'd1);
        check("R8 inversion committed", {9'd0, inv_o}, 10'd1);
        check("R3 corrected symbol", sym_o, D_NORM);

        // R10: reset while locked and inverted
        do_reset();

        // C: disagreeing verdicts, other payload between agreeing ones (R7, R8)
        nsym = 128;
        for (int k = 0; k < 3; k++) put_set(k, 0);
        put_set(3, 0);
        put_set(4, 1);
        put_set(5, 2);
        put_set(6, 1);
        put_set(7, 0);
        fill_exp(32, 112);
        run_stream(5, 1'b0);
        check("R7 swapped verdicts committed across other payload", {9'd0, inv_o}, 10'd1);

        // D: offset 0, three misses tolerated (R4), four drop lock, relock (R5)
        do_reset();
        nsym = 288;
        for (int k = 0; k < 18; k++) begin
            if ((k >= 6 && k <= 8) || (k >= 10 && k <= 13)) put_set(k, 3);
            else put_set(k, 0);
        end
        fill_exp(32, 100000);
        for (int j = 0; j < nsym; j++) begin
            e_lock[j] = (j >= 32 && j < 208) || (j >= 256);
            e_sos[j]  = e_lock[j] && (j % 16 == 0);
        end
        run_stream(0, 1'b0);
        check("R5 relocked after loss", {9'd0, lock_o}, 10'd1);
        check("R4 no inversion from comma-less sets", {9'd0, inv_o}, 10'd0);

        summary();
        $finish;
    end

endmodule